// File: doc/BRIEF.md
# Modem Line Status Monitor

This block watches four active-low modem input pins (carrier detect, ring indicator, data set ready and clear to send) and presents them to a host as one 8-bit status byte. The upper nibble gives the present level of each line, asserted as 1. The lower nibble holds sticky change flags. Every flag is cleared by a host read of the byte.

The block also owns a small modem-control register. That register drives four active-low output pins: terminal ready, request to send and two auxiliary outputs. One bit of the register switches the block into loopback. In loopback the control bits feed the status inputs in place of the pins, so software can test the status path without a cable. All external inputs pass through a synchroniser before any edge detection takes place.

Top module: `modem_line_monitor`

## Requirements
- R1: Status byte bit order, MSB first: carrier level, ring level, data-set-ready level, clear-to-send level, carrier change, ring trailing edge, data-set-ready change, clear-to-send change. A level reads 1 when its active-low pin is low.
- R2: The carrier, data-set-ready and clear-to-send change flags set on any level change of their line, in either direction, and stay set however many further changes follow.
- R3: The ring flag sets only when the ring pin goes from low to high, which is the end of a ring. A high-to-low transition leaves it clear.
- R4: The change flags hold until a read (`stat_rd` high for one cycle) and are all cleared at the clock edge that ends the read.
- R5: A change that sets a flag at the same edge as a read's clear leaves that flag set.
- R6: Control bit 0 drives `dtr_n_o` and bit 1 drives `rts_n_o`. Bit 2 drives `out1_n_o` and bit 3 drives `out2_n_o`. A 1 drives the pin low.
- R7: Control bits 7 to 5 read back as zero whatever value is written.
- R8: With control bit 4 set, the levels come from the control bits: clear-to-send follows bit 1, data-set-ready follows bit 0, ring follows bit 2 and carrier follows bit 3. Changes caused this way set flags under R2 and R3.
- R9: While loopback is on, all four output pins are high, and changes on the external input pins do not reach the status byte.
- R10: After reset, with all pins high, the status byte and the control register read 0x00 and all four output pins are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ctl_wr | input | 1 | Write strobe for the control register |
| ctl_wdata | input | 8 | Control register write data |
| ctl_q | output | 8 | Control register read-back |
| stat_rd | input | 1 | Status read strobe; clears the flags at the next edge |
| stat_q | output | 8 | Status byte |
| cd_n_i | input | 1 | Carrier detect pin, active low, asynchronous |
| ri_n_i | input | 1 | Ring indicator pin, active low, asynchronous |
| dsr_n_i | input | 1 | Data set ready pin, active low, asynchronous |
| cts_n_i | input | 1 | Clear to send pin, active low, asynchronous |
| dtr_n_o | output | 1 | Terminal ready pin, active low |
| rts_n_o | output | 1 | Request to send pin, active low |
| out1_n_o | output | 1 | Auxiliary output 1, active low |
| out2_n_o | output | 1 | Auxiliary output 2, active low |

## Verification
The assertions assume that `stat_rd` and `ctl_wr` are synchronous single-cycle strobes. They also assume that the pins may change at any time but are seen only after the synchroniser, so every property is stated on synchronised levels and never on raw pins. The stimulus drives all strobes and pins half a cycle away from the active edge. It holds each pin level for several cycles before a read, except in the one sequence that places a level change on the same edge as a read's clear. Loopback is entered and left only through register writes, and the external pins are moved while loopback is on to show that they have no effect.

// File: rtl/modem_pkg.sv
// Shared definitions for the modem line monitor.
// Assumes the four status lines are held in one vector ordered
// carrier, ring, data-set-ready, clear-to-send from MSB to LSB.
package modem_pkg;
    localparam int NUM_LINES = 4;
    localparam int LN_CTS    = 0;
    localparam int LN_DSR    = 1;
    localparam int LN_RI     = 2;
    localparam int LN_CD     = 3;
    localparam int CTL_BITS  = 5;

    // control register fields, bit 0 in the lowest position
    typedef struct packed {
        logic loop;
        logic aux2;
        logic aux1;
        logic rts;
        logic dtr;
    } modem_ctl_t;
endpackage

// File: rtl/modem_sync.sv
// Multi-flop synchroniser for a vector of asynchronous inputs.
// Assumes each bit is an independent level; no bus coherency is implied.
module modem_sync #(
    parameter int            WIDTH  = 4,
    parameter int            STAGES = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [WIDTH-1:0] stage_q [STAGES];

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            // one flop of the chain, reset to the inactive pin level
            always_ff @(posedge clk) begin
                if (!rst_n)      stage_q[s] <= RST_VAL;
                else if (s == 0) stage_q[s] <= async_i;
                else             stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
            end
        end
    endgenerate

    assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/modem_delta.sv
// Sticky change flag for one status line.
// Either variant is chosen by TRAILING_ONLY: any change, or only a 1->0
// fall of the asserted level (pin low->high). Assumes clr is a one-cycle
// read strobe; an event at the clearing edge wins over the clear.
module modem_delta #(
    parameter bit TRAILING_ONLY = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl_i,
    input  logic clr_i,
    output logic flag_o
);
    logic prev_q;
    logic flag_q;
    logic evt;

    // previous level, reset to deasserted
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= lvl_i;
    end

    generate
        if (TRAILING_ONLY) begin : g_trail
            assign evt = prev_q & ~lvl_i;
        end else begin : g_any
            assign evt = prev_q ^ lvl_i;
        end
    endgenerate

    // flag update: set has priority over clear
    always_ff @(posedge clk) begin
        if (!rst_n)     flag_q <= 1'b0;
        else if (evt)   flag_q <= 1'b1;
        else if (clr_i) flag_q <= 1'b0;
    end

    assign flag_o = flag_q;

    // R4
    sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q && !clr_i) |=> flag_q);
    // R4
    clear_on_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && (prev_q == lvl_i)) |=> !flag_q);
    // R5
    change_beats_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && (prev_q != lvl_i) && (!TRAILING_ONLY || prev_q)) |=> flag_q);
    generate
        if (TRAILING_ONLY) begin : g_trail_chk
            // R3
            no_leading_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (!prev_q && lvl_i && !flag_q) |=> !flag_q);
        end
    endgenerate
endmodule

// File: rtl/modem_ctrl_reg.sv
// Modem control register: holds output enables and the loopback switch.
// Assumes ctl_wr is a synchronous strobe; reserved upper bits are dropped.
module modem_ctrl_reg
    import modem_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output modem_ctl_t        ctl_o,
    output logic [DATA_W-1:0] rdata_o
);
    localparam int PAD_W = DATA_W - CTL_BITS;

    modem_ctl_t ctl_q;

    // register update on write
    always_ff @(posedge clk) begin
        if (!rst_n)    ctl_q <= '0;
        else if (wr_i) ctl_q <= modem_ctl_t'(wdata_i[CTL_BITS-1:0]);
    end

    assign ctl_o   = ctl_q;
    assign rdata_o = {{PAD_W{1'b0}}, ctl_q};

    // R7
    readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_i |=> (rdata_o == {{PAD_W{1'b0}}, $past(wdata_i[CTL_BITS-1:0])}));
endmodule

// File: rtl/modem_line_monitor.sv
// Modem line monitor top: synchronises the four status pins, muxes in
// loopback sources, keeps sticky change flags and drives control pins.
// Assumes asynchronous pins; strobes are synchronous to clk.
module modem_line_monitor
    import modem_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int DATA_W      = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_wr,
    input  logic [DATA_W-1:0] ctl_wdata,
    output logic [DATA_W-1:0] ctl_q,
    input  logic              stat_rd,
    output logic [DATA_W-1:0] stat_q,
    input  logic              cd_n_i,
    input  logic              ri_n_i,
    input  logic              dsr_n_i,
    input  logic              cts_n_i,
    output logic              dtr_n_o,
    output logic              rts_n_o,
    output logic              out1_n_o,
    output logic              out2_n_o
);
    modem_ctl_t           ctl;
    logic [NUM_LINES-1:0] pin_sync_n;
    logic [NUM_LINES-1:0] ext_lvl;
    logic [NUM_LINES-1:0] loop_lvl;
    logic [NUM_LINES-1:0] lvl;
    logic [NUM_LINES-1:0] flags;

    modem_ctrl_reg #(.DATA_W(DATA_W)) u_ctl (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (ctl_wr),
        .wdata_i (ctl_wdata),
        .ctl_o   (ctl),
        .rdata_o (ctl_q)
    );

    modem_sync #(.WIDTH(NUM_LINES), .STAGES(SYNC_STAGES), .RST_VAL('1)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({cd_n_i, ri_n_i, dsr_n_i, cts_n_i}),
        .sync_o  (pin_sync_n)
    );

    // source selection: pins (inverted) or control bits in loopback
    always_comb begin
        ext_lvl            = ~pin_sync_n;
        loop_lvl[LN_CTS]   = ctl.rts;
        loop_lvl[LN_DSR]   = ctl.dtr;
        loop_lvl[LN_RI]    = ctl.aux1;
        loop_lvl[LN_CD]    = ctl.aux2;
        lvl                = ctl.loop ? loop_lvl : ext_lvl;
    end

    genvar i;
    generate
        for (i = 0; i < NUM_LINES; i++) begin : g_line
            modem_delta #(.TRAILING_ONLY(i == LN_RI)) u_delta (
                .clk    (clk),
                .rst_n  (rst_n),
                .lvl_i  (lvl[i]),
                .clr_i  (stat_rd),
                .flag_o (flags[i])
            );
        end
    endgenerate

    assign stat_q = {lvl, flags};

    // output pins: active low, forced inactive in loopback
    always_comb begin
        dtr_n_o  = ctl.loop | ~ctl.dtr;
        rts_n_o  = ctl.loop | ~ctl.rts;
        out1_n_o = ctl.loop | ~ctl.aux1;
        out2_n_o = ctl.loop | ~ctl.aux2;
    end

    // R9
    loop_pins_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_q[4] |-> (dtr_n_o && rts_n_o && out1_n_o && out2_n_o));
    // R8
    loop_map_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_q[4] |-> (stat_q[7:4] == {ctl_q[3], ctl_q[2], ctl_q[0], ctl_q[1]}));
    // R6
    pin_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_q[4] |-> ({out2_n_o, out1_n_o, rts_n_o, dtr_n_o} == ~ctl_q[3:0]));
endmodule

// File: tb/modem_line_monitor_bench.sv
// Scoreboard bench: read tasks queue expected bytes, a monitor compares.
module modem_line_monitor_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ctl_wr = 1'b0;
    logic [7:0] ctl_wdata = '0;
    logic [7:0] ctl_q;
    logic       stat_rd = 1'b0;
    logic [7:0] stat_q;
    logic       cd_n = 1'b1, ri_n = 1'b1, dsr_n = 1'b1, cts_n = 1'b1;
    logic       dtr_n_o, rts_n_o, out1_n_o, out2_n_o;

    int vectors = 0;
    int errors  = 0;
    logic [7:0] exp_q [$];
    string      tag_q [$];

    always #2 clk = ~clk;

    modem_line_monitor u_modem_line_monitor (
        .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
        .ctl_q(ctl_q), .stat_rd(stat_rd), .stat_q(stat_q),
        .cd_n_i(cd_n), .ri_n_i(ri_n), .dsr_n_i(dsr_n), .cts_n_i(cts_n),
        .dtr_n_o(dtr_n_o), .rts_n_o(rts_n_o), .out1_n_o(out1_n_o), .out2_n_o(out2_n_o)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %02h expected %02h", tag, act, exp);
        end
    endtask

    // monitor: pops one expectation per read cycle
    always @(negedge clk) begin
        #1;
        if (stat_rd) begin
            if (exp_q.size() == 0) check("scoreboard-empty", 8'hxx, 8'h00);
            else check(tag_q.pop_front(), stat_q, exp_q.pop_front());
        end
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // called at a negedge; read lasts one cycle
    task automatic rd(input logic [7:0] exp, input string tag);
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        stat_rd = 1'b1;
        @(negedge clk);
        stat_rd = 1'b0;
    endtask

    task automatic wr(input logic [7:0] d);
        ctl_wr = 1'b1;
        ctl_wdata = d;
        @(negedge clk);
        ctl_wr = 1'b0;
        #1;
    endtask

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(2);
        check("R10 ctl reset", ctl_q, 8'h00);
        check("R10 pins reset", {4'h0, out2_n_o, out1_n_o, rts_n_o, dtr_n_o}, 8'h0F);
        @(negedge clk); rd(8'h00, "R10 status reset");

        cts_n = 1'b0; idle(4);
        rd(8'h11, "R2 cts assert");
        rd(8'h10, "R4 flags cleared");

        cd_n = 1'b0; dsr_n = 1'b0; idle(4);
        rd(8'hBA, "R1 cd+dsr layout");
        rd(8'hB0, "R4 cleared after cd+dsr");

        ri_n = 1'b0; idle(4);
        rd(8'hF0, "R3 ring leading edge no flag");
        ri_n = 1'b1; idle(4);
        rd(8'hB4, "R3 ring trailing edge");

        cts_n = 1'b1; idle(3); cts_n = 1'b0; idle(4);
        rd(8'hB1, "R2 double change");

        // change lands on the clearing edge
        cts_n = 1'b1; idle(2);
        rd(8'hA0, "R5 read during change");
        idle(1);
        rd(8'hA1, "R5 flag kept");

        wr(8'h0F);
        check("R6 pins driven", {4'h0, out2_n_o, out1_n_o, rts_n_o, dtr_n_o}, 8'h00);
        wr(8'h05);
        check("R6 pins dtr+out1", {4'h0, out2_n_o, out1_n_o, rts_n_o, dtr_n_o}, 8'h0A);
        wr(8'hFF);
        check("R7 reserved zero", ctl_q, 8'h1F);
        check("R9 loop pins idle", {4'h0, out2_n_o, out1_n_o, rts_n_o, dtr_n_o}, 8'h0F);
        idle(2);
        rd(8'hF1, "R8 loopback all on");
        wr(8'h10);
        idle(2);
        rd(8'h0F, "R8 loopback all off");
        cts_n = 1'b0; dsr_n = 1'b1; ri_n = 1'b0; idle(5);
        rd(8'h00, "R9 pins ignored in loop");
        cd_n = 1'b1; cts_n = 1'b1; ri_n = 1'b1; idle(4);
        wr(8'h00);
        idle(2);
        rd(8'h00, "R9 leave loop quiet");
        idle(3);
        if (exp_q.size() != 0) check("scoreboard-leftover", 8'(exp_q.size()), 8'h00);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        #40000;
        errors++;
        vectors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule